// File: doc/BRIEF.md
# SDRAM Open-Page Command Scheduler

This block converts a stream of memory access requests into SDRAM commands for a single device with four internal banks. Each request carries a bank, row and column address, a read/write flag and a requester class (fast or normal). The scheduler keeps a table that records which row is open in each bank. It issues one command per clock. A request that hits an open row goes straight to a column command. A request that misses is first handled with precharge and activate commands. A request is accepted (`reqReady` high) in the cycle its column command is decided. The command appears on the registered SDRAM pins one cycle later.

The scheduler can overlap row opening across banks. On a miss to a bank that has no open row, it activates the new row before it closes the row left open in another bank. The precharge of the old row then runs while the new row waits out its activate-to-column delay. A configuration input turns off this overlap. Another configuration input decides whether the open row is closed when the request stream goes idle. A refresh request closes all open rows with a precharge-all and then issues REFRESH. Bursts are modelled as `BL` data cycles that begin at the column command.

Top module: `sdram_page_sched`

## Requirements
- R1: A request whose bank holds its row open is served by a READ (`reqWrite`=0) or WRITE (`reqWrite`=1) with no ACTIVATE or PRECHARGE first. The column sits on `sdAddr` with bit 10 low, and the row stays open after the burst.
- R2: A column command to a bank comes at least `T_RCD` cycles after that bank's ACTIVATE. An ACTIVATE comes at least `T_RP` cycles after a precharge of the same bank and at least `T_RFC` cycles after a REFRESH. A REFRESH comes at least `T_RP` cycles after the last precharge.
- R3: When column commands are issued as early as allowed, consecutive ones are exactly `BL` cycles apart for a fast-class request (`reqFast`=1, no idle data cycle) and `BL`+1 cycles apart for a normal-class request.
- R4: With `cfgNoOverlap`=0, a miss to a bank with no open row, while another bank holds an open row, is served with ACTIVATE to the new bank as the first command. The PRECHARGE of the other bank follows it.
- R5: With `cfgNoOverlap`=1, the same case is served with PRECHARGE of the other bank first and ACTIVATE of the new bank second.
- R6: A miss to a bank that holds a different open row is served with PRECHARGE of that bank, then ACTIVATE of the new row exactly `T_RP` cycles later, then the column command.
- R7: With no request and no refresh pending, `cfgKeepOpen`=0 closes open rows with PRECHARGE. `cfgKeepOpen`=1 leaves the row used by the last column command open.
- R8: A single-bank PRECHARGE drives `sdAddr[10]`=0 and the bank on `sdBank`. A precharge-all drives `sdAddr[10]`=1 and leaves every bank closed.
- R9: A refresh request issues precharge-all first if any row is open. REFRESH is issued only when every bank is closed, and `refAck` is high in the same cycle as REFRESH on the pins. A pending refresh goes ahead of an access that has not yet reached its column command.
- R10: Pin encoding with chip select low and {RAS,CAS,WE} active low: ACTIVATE 011, READ 101, WRITE 100, PRECHARGE 010, REFRESH 001. An idle cycle deselects (`sdCsN`=1, 111). During reset the pins are idle and `reqReady` and `refAck` are low.
- R11: A precharge (single or all) that closes the bank of the last column command comes no earlier than `BL` cycles after that column command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request valid |
| reqReady | output | 1 | Request accepted this cycle (column command decided) |
| reqBank | input | BW | Request bank |
| reqRow | input | RW | Request row |
| reqCol | input | CW | Request column |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqFast | input | 1 | Requester class: 1 = fast (no data gap) |
| refReq | input | 1 | Refresh request, held until `refAck` |
| refAck | output | 1 | High with REFRESH on the pins |
| cfgKeepOpen | input | 1 | Keep the row open when idle |
| cfgNoOverlap | input | 1 | Disable activate-before-precharge across banks |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBank | output | BW | Bank address |
| sdAddr | output | RW | Row/column address; bit 10 selects all banks on precharge |

## Verification
Same-row request runs with both requester classes show apart the zero-gap and one-gap column spacing. Requests that move to a closed bank, once with overlap and once without, show which of ACTIVATE and PRECHARGE comes first. A request to an open bank with a new row shows the close-then-reopen path and its `T_RP` wait. Idle periods under both idle-close settings, and refresh requests raised with rows closed, with a row open and together with a new access, cover the remaining command orders. A long sweep over banks, rows, classes and both configuration bits is checked cycle by cycle against a bench model of open rows and timing windows.

// File: rtl/sdsched_pkg.sv
package sdsched_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_PALL,
    CMD_REF
  } cmd_e;

  // strobes from the selector to the bank table / pin stage
  typedef struct packed {
    cmd_e cmd;
    logic takeReq;
  } strobe_t;

endpackage

// File: rtl/sdsched_path.sv
module sdsched_path
  import sdsched_pkg::*;
#(
  parameter int NB    = 4,
  parameter int BW    = 2,
  parameter int RW    = 13,
  parameter int CW    = 10,
  parameter int BL    = 4,
  parameter int T_RCD = 3,
  parameter int T_RP  = 2,
  parameter int T_RFC = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [BW-1:0] tgtBank,
  input  logic [BW-1:0] reqBank,
  input  logic [RW-1:0] reqRow,
  input  logic [CW-1:0] reqCol,
  output logic [NB-1:0] openVld,
  output logic          rowHit,
  output logic [NB-1:0] bankIdle,
  output logic          refIdle,
  output logic          colFastOk,
  output logic          colSlowOk,
  output logic          colBusy,
  output logic [BW-1:0] lastBank,
  output logic          refAck,
  output logic          sdCsN,
  output logic          sdRasN,
  output logic          sdCasN,
  output logic          sdWeN,
  output logic [BW-1:0] sdBank,
  output logic [RW-1:0] sdAddr
);
  localparam int M1 = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int M2 = (M1 > T_RFC) ? M1 : T_RFC;
  localparam int M3 = (M2 > BL) ? M2 : BL;
  localparam int TW = $clog2(M3 + 1);
  localparam int AP_BIT = 10;
  localparam logic [RW-1:0] AP_MASK = RW'(1) << AP_BIT;

  logic [RW-1:0] openRow [NB];
  logic [TW-1:0] bankCnt [NB];
  logic [TW-1:0] refCnt;
  logic [TW-1:0] colCnt;
  logic [3:0]    pins;

  // bank table: open row, valid flag and per-bank wait counter
  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (!rstN) begin
        openVld[b] <= 1'b0;
        openRow[b] <= '0;
        bankCnt[b] <= '0;
      end else if (stb.cmd == CMD_ACT && tgtBank == BW'(b)) begin
        openVld[b] <= 1'b1;
        openRow[b] <= reqRow;
        bankCnt[b] <= TW'(T_RCD - 1);
      end else if ((stb.cmd == CMD_PRE && tgtBank == BW'(b)) || stb.cmd == CMD_PALL) begin
        openVld[b] <= 1'b0;
        bankCnt[b] <= TW'(T_RP - 1);
      end else if (bankCnt[b] != '0) begin
        bankCnt[b] <= bankCnt[b] - 1'b1;
      end
    end
  end

  // refresh recovery and column/burst spacing counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt   <= '0;
      colCnt   <= '0;
      lastBank <= '0;
    end else begin
      if (stb.cmd == CMD_REF) refCnt <= TW'(T_RFC - 1);
      else if (refCnt != '0)  refCnt <= refCnt - 1'b1;
      if (stb.cmd == CMD_RD || stb.cmd == CMD_WR) begin
        colCnt   <= TW'(BL);
        lastBank <= tgtBank;
      end else if (colCnt != '0) begin
        colCnt <= colCnt - 1'b1;
      end
    end
  end

  // registered pin stage: {cs, ras, cas, we}
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pins   <= 4'b1111;
      sdBank <= '0;
      sdAddr <= '0;
      refAck <= 1'b0;
    end else begin
      sdBank <= tgtBank;
      refAck <= (stb.cmd == CMD_REF);
      case (stb.cmd)
        CMD_ACT:  begin pins <= 4'b0011; sdAddr <= reqRow; end
        CMD_RD:   begin pins <= 4'b0101; sdAddr <= {{(RW-CW){1'b0}}, reqCol}; end
        CMD_WR:   begin pins <= 4'b0100; sdAddr <= {{(RW-CW){1'b0}}, reqCol}; end
        CMD_PRE:  begin pins <= 4'b0010; sdAddr <= '0; end
        CMD_PALL: begin pins <= 4'b0010; sdAddr <= AP_MASK; end
        CMD_REF:  begin pins <= 4'b0001; sdAddr <= '0; end
        default:  begin pins <= 4'b1111; sdAddr <= '0; end
      endcase
    end
  end

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = pins;

  always_comb begin
    for (int b = 0; b < NB; b++) bankIdle[b] = (bankCnt[b] == '0);
  end
  assign rowHit    = openVld[reqBank] && (openRow[reqBank] == reqRow);
  assign refIdle   = (refCnt == '0);
  assign colFastOk = (colCnt <= TW'(1));
  assign colSlowOk = (colCnt == '0);
  assign colBusy   = (colCnt > TW'(1));

  // R1 / R2: column only to an open bank whose activate delay has run out
  a_r1_col_open: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cmd == CMD_RD || stb.cmd == CMD_WR) |-> (openVld[tgtBank] && bankCnt[tgtBank] == '0));

  // R2: activate only to a closed, recovered bank outside refresh recovery
  a_r2_act_ready: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cmd == CMD_ACT) |-> (!openVld[tgtBank] && bankCnt[tgtBank] == '0 && refCnt == '0));

  // R9: refresh only with every bank closed
  a_r9_ref_closed: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cmd == CMD_REF) |-> (openVld == '0));

  // R8: precharge-all drives bit 10 high and closes every bank
  a_r8_pall_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cmd == CMD_PALL) |=> (openVld == '0 && sdAddr[AP_BIT] && !sdRasN && sdCasN && !sdWeN));

  // R3: no column command while the previous burst still needs its slot
  a_r3_col_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cmd == CMD_RD || stb.cmd == CMD_WR) |-> (colCnt <= TW'(1)));

  // R11: the bursting bank is not precharged before its burst ends
  a_r11_pre_after_burst: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cmd == CMD_PRE) |-> !(colBusy && lastBank == tgtBank));

endmodule

// File: rtl/sdsched_ctrl.sv
module sdsched_ctrl
  import sdsched_pkg::*;
#(
  parameter int NB = 4,
  parameter int BW = 2
) (
  input  logic          reqValid,
  input  logic [BW-1:0] reqBank,
  input  logic          reqWrite,
  input  logic          reqFast,
  input  logic          refReq,
  input  logic          cfgKeepOpen,
  input  logic          cfgNoOverlap,
  input  logic [NB-1:0] openVld,
  input  logic          rowHit,
  input  logic [NB-1:0] bankIdle,
  input  logic          refIdle,
  input  logic          colFastOk,
  input  logic          colSlowOk,
  input  logic          colBusy,
  input  logic [BW-1:0] lastBank,
  output strobe_t       stb,
  output logic [BW-1:0] tgtBank,
  output logic          reqReady
);
  logic [NB-1:0] reqSel, lastSel, closable, strayReq, strayIdle;

  function automatic logic [BW-1:0] lowIdx(input logic [NB-1:0] m);
    lowIdx = '0;
    for (int i = NB - 1; i >= 0; i--) if (m[i]) lowIdx = BW'(i);
  endfunction

  assign reqSel  = NB'(1) << reqBank;
  assign lastSel = NB'(1) << lastBank;

  always_comb begin
    for (int x = 0; x < NB; x++)
      closable[x] = openVld[x] && bankIdle[x] && !(colBusy && lastBank == BW'(x));
  end
  assign strayReq  = closable & ~reqSel;
  assign strayIdle = cfgKeepOpen ? (closable & ~lastSel) : closable;

  always_comb begin
    stb.cmd     = CMD_NOP;
    stb.takeReq = 1'b0;
    tgtBank     = reqBank;
    if (refReq) begin
      if (|openVld) begin
        if (!colBusy && &(bankIdle | ~openVld)) stb.cmd = CMD_PALL;
      end else if (&bankIdle && refIdle) begin
        stb.cmd = CMD_REF;
      end
    end else if (reqValid) begin
      if (rowHit) begin
        if (bankIdle[reqBank] && (reqFast ? colFastOk : colSlowOk)) begin
          stb.cmd     = reqWrite ? CMD_WR : CMD_RD;
          stb.takeReq = 1'b1;
        end else if (|strayReq) begin
          stb.cmd = CMD_PRE;
          tgtBank = lowIdx(strayReq);
        end
      end else if (openVld[reqBank]) begin
        if (closable[reqBank]) stb.cmd = CMD_PRE;
      end else if (cfgNoOverlap && |(openVld & ~reqSel)) begin
        if (|strayReq) begin
          stb.cmd = CMD_PRE;
          tgtBank = lowIdx(strayReq);
        end
      end else if (bankIdle[reqBank] && refIdle) begin
        stb.cmd = CMD_ACT;
      end
    end else if (|strayIdle) begin
      stb.cmd = CMD_PRE;
      tgtBank = lowIdx(strayIdle);
    end
  end

  assign reqReady = stb.takeReq;

endmodule

// File: rtl/sdram_page_sched.sv
module sdram_page_sched
  import sdsched_pkg::*;
#(
  parameter int NB    = 4,
  parameter int RW    = 13,
  parameter int CW    = 10,
  parameter int BL    = 4,
  parameter int T_RCD = 3,
  parameter int T_RP  = 2,
  parameter int T_RFC = 7,
  localparam int BW   = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [BW-1:0] reqBank,
  input  logic [RW-1:0] reqRow,
  input  logic [CW-1:0] reqCol,
  input  logic          reqWrite,
  input  logic          reqFast,
  input  logic          refReq,
  output logic          refAck,
  input  logic          cfgKeepOpen,
  input  logic          cfgNoOverlap,
  output logic          sdCsN,
  output logic          sdRasN,
  output logic          sdCasN,
  output logic          sdWeN,
  output logic [BW-1:0] sdBank,
  output logic [RW-1:0] sdAddr
);
  strobe_t       stb;
  logic [BW-1:0] tgtBank, lastBank;
  logic [NB-1:0] openVld, bankIdle;
  logic          rowHit, refIdle, colFastOk, colSlowOk, colBusy;

  sdsched_ctrl #(.NB(NB), .BW(BW)) uCtrl (
    .reqValid(reqValid), .reqBank(reqBank), .reqWrite(reqWrite), .reqFast(reqFast),
    .refReq(refReq), .cfgKeepOpen(cfgKeepOpen), .cfgNoOverlap(cfgNoOverlap),
    .openVld(openVld), .rowHit(rowHit), .bankIdle(bankIdle), .refIdle(refIdle),
    .colFastOk(colFastOk), .colSlowOk(colSlowOk), .colBusy(colBusy), .lastBank(lastBank),
    .stb(stb), .tgtBank(tgtBank), .reqReady(reqReady)
  );

  sdsched_path #(.NB(NB), .BW(BW), .RW(RW), .CW(CW), .BL(BL),
                 .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .tgtBank(tgtBank), .reqBank(reqBank),
    .reqRow(reqRow), .reqCol(reqCol), .openVld(openVld), .rowHit(rowHit),
    .bankIdle(bankIdle), .refIdle(refIdle), .colFastOk(colFastOk), .colSlowOk(colSlowOk),
    .colBusy(colBusy), .lastBank(lastBank), .refAck(refAck), .sdCsN(sdCsN),
    .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN), .sdBank(sdBank), .sdAddr(sdAddr)
  );

endmodule

// File: tb/tb_sdram_page_sched.sv
`timescale 1ns/100ps
module tb_sdram_page_sched;
  localparam int BL = 4, T_RCD = 3, T_RP = 2, T_RFC = 7;
  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_PALL = 5, C_REF = 6, C_BAD = 7;
  localparam int LIMIT = 100000;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0, reqFast = 0, refReq = 0;
  logic cfgKeepOpen = 1, cfgNoOverlap = 0;
  logic [1:0] reqBank = 0;
  logic [12:0] reqRow = 0;
  logic [9:0] reqCol = 0;
  logic reqReady, refAck, sdCsN, sdRasN, sdCasN, sdWeN;
  logic [1:0] sdBank;
  logic [12:0] sdAddr;

  always #2.5 clk = ~clk;

  sdram_page_sched dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqBank(reqBank),
    .reqRow(reqRow), .reqCol(reqCol), .reqWrite(reqWrite), .reqFast(reqFast),
    .refReq(refReq), .refAck(refAck), .cfgKeepOpen(cfgKeepOpen), .cfgNoOverlap(cfgNoOverlap),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN), .sdBank(sdBank), .sdAddr(sdAddr)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit mOpen [4];
  int mRow [4], mActC [4], mPreC [4];
  int lastColC = -100, lastColBank = -1, lastRefC = -100, lastPreC = -100;
  int pendBank = 0, pendRow = 0, accBank = 0, accRow = 0, accCol = 0;
  bit accWr = 0, accFast = 0;
  int logCmd [2048], logBank [2048], logC [2048];
  int logN = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int findCmd(input int c, input int b, input int from);
    for (int i = from; i < logN; i++) if (logCmd[i] == c && (b < 0 || logBank[i] == b)) return i;
    return -1;
  endfunction

  // pin monitor and protocol model
  always @(negedge clk) begin
    if (rstN) begin
      int c, b;
      cyc++;
      b = int'(sdBank);
      if (sdCsN) c = C_NOP;
      else case ({sdRasN, sdCasN, sdWeN})
        3'b011: c = C_ACT;
        3'b101: c = C_RD;
        3'b100: c = C_WR;
        3'b010: c = sdAddr[10] ? C_PALL : C_PRE;
        3'b001: c = C_REF;
        default: c = C_BAD;
      endcase
      if (c != C_NOP && logN < 2048) begin
        logCmd[logN] = c; logBank[logN] = b; logC[logN] = cyc; logN++;
      end
      if (c == C_REF || refAck) chk(c == C_REF && refAck, "R9", "refAck with REFRESH", int'(refAck), 1);
      case (c)
        C_BAD: chk(0, "R10", "illegal pin code", int'({sdRasN, sdCasN, sdWeN}), 7);
        C_ACT: begin
          chk(!mOpen[b], "R2", "activate to open bank", b, -1);
          chk(b == pendBank && int'(sdAddr) == pendRow, "R1", "activate row", int'(sdAddr), pendRow);
          chk(cyc - mPreC[b] >= T_RP, "R2", "precharge to activate", cyc - mPreC[b], T_RP);
          chk(cyc - lastRefC >= T_RFC, "R2", "refresh to activate", cyc - lastRefC, T_RFC);
          mOpen[b] = 1; mRow[b] = int'(sdAddr); mActC[b] = cyc;
        end
        C_RD, C_WR: begin
          chk(mOpen[b] && mRow[b] == accRow && b == accBank, "R1", "column bank/row", b, accBank);
          chk(int'(sdAddr) == accCol, "R1", "column address", int'(sdAddr), accCol);
          chk((c == C_WR) == accWr, "R10", "read/write code", c, accWr ? C_WR : C_RD);
          chk(cyc - mActC[b] >= T_RCD, "R2", "activate to column", cyc - mActC[b], T_RCD);
          chk(cyc - lastColC >= BL + (accFast ? 0 : 1), "R3", "column gap", cyc - lastColC, BL + (accFast ? 0 : 1));
          lastColC = cyc; lastColBank = b;
        end
        C_PRE: begin
          chk(mOpen[b], "R8", "precharge of open bank", b, b);
          if (b == lastColBank) chk(cyc - lastColC >= BL, "R11", "burst end to precharge", cyc - lastColC, BL);
          mOpen[b] = 0; mPreC[b] = cyc; lastPreC = cyc;
        end
        C_PALL: begin
          chk(cyc - lastColC >= BL, "R11", "burst end to precharge-all", cyc - lastColC, BL);
          for (int i = 0; i < 4; i++) begin
            if (mOpen[i]) mPreC[i] = cyc;
            mOpen[i] = 0;
          end
          lastPreC = cyc;
        end
        C_REF: begin
          chk(!(mOpen[0] | mOpen[1] | mOpen[2] | mOpen[3]), "R9", "refresh with open row", 1, 0);
          chk(cyc - lastPreC >= T_RP, "R2", "precharge to refresh", cyc - lastPreC, T_RP);
          lastRefC = cyc;
        end
        default: ;
      endcase
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > LIMIT) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, LIMIT);
      finishRun();
    end
  end

  task automatic access(input int b, input int r, input int c, input bit wr, input bit fast);
    pendBank = b; pendRow = r;
    reqBank = 2'(b); reqRow = 13'(r); reqCol = 10'(c); reqWrite = wr; reqFast = fast; reqValid = 1;
    #1;
    while (!reqReady) @(negedge clk);
    @(posedge clk); #1;
    reqValid = 0;
    accBank = b; accRow = r; accCol = c; accWr = wr; accFast = fast;
  endtask

  task automatic refresh();
    refReq = 1; #1;
    while (!refAck) @(negedge clk);
    refReq = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int m, a, p, q;
    for (int i = 0; i < 4; i++) begin mOpen[i] = 0; mRow[i] = 0; mActC[i] = -100; mPreC[i] = -100; end
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(sdCsN && sdRasN && sdCasN && sdWeN, "R10", "reset pins idle", int'({sdCsN, sdRasN, sdCasN, sdWeN}), 15);
    chk(!reqReady && !refAck, "R10", "reset handshakes low", int'({reqReady, refAck}), 0);
    rstN = 1;
    idle(2);

    // R1/R3: fast same-row run
    m = logN;
    access(0, 5, 8, 0, 1); access(0, 5, 16, 0, 1); access(0, 5, 24, 1, 1);
    idle(8);
    chk(logCmd[m] == C_ACT && logCmd[m+1] == C_RD && logCmd[m+3] == C_WR, "R1", "hit sequence", logCmd[m+1], C_RD);
    chk(findCmd(C_ACT, -1, m + 1) < 0 && findCmd(C_PRE, -1, m) < 0, "R1", "no extra row commands", findCmd(C_ACT, -1, m + 1), -1);
    chk(logC[m+2] - logC[m+1] == BL, "R3", "fast gap", logC[m+2] - logC[m+1], BL);
    chk(logC[m+3] - logC[m+2] == BL, "R3", "fast gap write", logC[m+3] - logC[m+2], BL);

    // R3: normal-class run
    m = logN;
    access(0, 5, 1, 0, 0); access(0, 5, 2, 0, 0);
    idle(8);
    chk(logCmd[m] == C_RD && logC[m+1] - logC[m] == BL + 1, "R3", "normal gap", logC[m+1] - logC[m], BL + 1);

    // R4: overlap on
    m = logN;
    access(1, 7, 3, 0, 1);
    idle(10);
    a = findCmd(C_ACT, 1, m); p = findCmd(C_PRE, 0, m);
    chk(logCmd[m] == C_ACT && logBank[m] == 1, "R4", "activate first", logCmd[m], C_ACT);
    chk(a >= 0 && p > a, "R4", "old row closed after", p, a + 1);

    // R5: overlap off
    cfgNoOverlap = 1;
    m = logN;
    access(2, 3, 4, 0, 1);
    idle(10);
    chk(logCmd[m] == C_PRE && logBank[m] == 1, "R5", "precharge first", logCmd[m], C_PRE);
    chk(logCmd[m+1] == C_ACT && logBank[m+1] == 2, "R5", "activate second", logCmd[m+1], C_ACT);
    cfgNoOverlap = 0;

    // R6: same-bank miss
    m = logN;
    access(2, 9, 5, 1, 1);
    idle(10);
    chk(logCmd[m] == C_PRE && logBank[m] == 2, "R6", "close same bank", logCmd[m], C_PRE);
    chk(logCmd[m+1] == C_ACT && logC[m+1] - logC[m] == T_RP, "R6", "reopen after tRP", logC[m+1] - logC[m], T_RP);
    chk(logCmd[m+2] == C_WR, "R6", "column after reopen", logCmd[m+2], C_WR);

    // R7: keep-open holds, idle-close closes
    m = logN;
    idle(20);
    chk(logN == m && mOpen[2], "R7", "row kept open", logN - m, 0);
    cfgKeepOpen = 0;
    m = logN;
    idle(10);
    chk(logCmd[m] == C_PRE && logBank[m] == 2, "R7", "idle close", logCmd[m], C_PRE);
    chk(!(mOpen[0] | mOpen[1] | mOpen[2] | mOpen[3]), "R7", "all closed", 1, 0);

    // R9: refresh with nothing open
    m = logN;
    refresh();
    idle(10);
    chk(logCmd[m] == C_REF, "R9", "direct refresh", logCmd[m], C_REF);

    // R8/R9: refresh with a row open
    cfgKeepOpen = 1;
    access(3, 1, 0, 0, 1);
    idle(6);
    m = logN;
    refresh();
    idle(10);
    chk(logCmd[m] == C_PALL, "R8", "precharge-all first", logCmd[m], C_PALL);
    chk(logCmd[m+1] == C_REF, "R9", "refresh after close", logCmd[m+1], C_REF);

    // R9: refresh goes ahead of a waiting access
    access(3, 1, 0, 0, 1);
    idle(6);
    m = logN;
    fork
      refresh();
      access(0, 2, 7, 0, 1);
    join
    idle(10);
    p = findCmd(C_PALL, -1, m); q = findCmd(C_REF, -1, m); a = findCmd(C_ACT, 0, m);
    chk(p >= 0 && q > p && a > q, "R9", "refresh priority order", a, q + 1);

    // sweep over banks, rows, classes and configuration
    for (int ov = 0; ov < 2; ov++) begin
      for (int ko = 0; ko < 2; ko++) begin
        cfgNoOverlap = ov[0]; cfgKeepOpen = ko[0];
        for (int i = 0; i < 24; i++) begin
          access((i * 3 + ov) % 4, (i / 2) % 3, i * 5, (i / 3) % 2 == 1, i % 2 == 1);
          if (i % 3 == 2) idle(i % 7);
          if (i % 8 == 7) refresh();
        end
        idle(12);
      end
    end
    idle(10);
    finishRun();
  end
endmodule